// File: doc/BRIEF.md
# Prioritized Interrupt Controller with Register Bus

This block collects a parameterized set of interrupt inputs (64 by default) and turns them into a single request line to a processor. Software reaches it over a 32-bit register bus that does one read or one write per cycle. Each source has its own configuration word. That word selects level or rising-edge sensitivity and sets a priority level.

Enables are never written as a whole word. Software changes them through one-hot set and clear registers, each 32 bits wide, with one pair of registers per bank of 32 sources. A global generation bit gates the request line. A vector register returns the winning source number. An end-of-interrupt register closes the service of the current interrupt. A soft-reset register clears the whole block.

Reading a valid vector places that source's level in service. Until end-of-interrupt is written, only a strictly higher level can raise the request again.

Top module: `irq_ctrl_top`

## Requirements
- R1: After reset, every enable, every configuration word and the generation bit read as zero, `irq_o` is low, and the vector register (byte address 0x008) reads 64.
- R2: A write to the set register of bank b (address 0x040+4b) enables source 32b+k for each bit k written as one and leaves every other source unchanged. A read at either the set or the clear address of bank b returns that bank's current enable mask.
- R3: A write to the clear register of bank b (address 0x060+4b) disables source 32b+k for each bit k written as one and leaves every other source unchanged.
- R4: Source n has a configuration word at address 0x200+8n. Bit 0 selects edge mode when set and level mode when clear. Bits 3:1 hold the priority level. The word reads back as it was written.
- R5: A level-mode source is pending while it is enabled and its input is high. A source that is not enabled never becomes pending, whatever its input does.
- R6: An edge-mode source latches a rising edge of its input. The latch is cleared by any configuration write with bit 0 at zero, so writing the word with the edge bit cleared and then writing the original word back drops a captured edge.
- R7: The vector register returns the number of the pending source with the highest level. When levels are equal, the lowest source number wins. When nothing is pending, it returns 64.
- R8: `irq_o` is a register. It can be high only when bit 0 of the control register (0x000) is set, and it rises one clock after that bit and a qualifying pending source are both present.
- R9: A vector read that returns a valid source puts that source's level in service. While a level is in service, `irq_o` is asserted only for a pending level strictly above it. Any write to the end-of-interrupt register (0x00C) ends service, and `irq_o` is re-evaluated on the following clock.
- R10: Writing a one to bit 0 of the soft-reset register (0x004) returns every enable, configuration, edge latch, the generation bit and the service state to zero at that clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| src_i | input | NSRC | Interrupt inputs, synchronous to clk_i |
| bus_addr_i | input | 10 | Byte address, word aligned |
| bus_wr_i | input | 1 | Write strobe |
| bus_wdata_i | input | 32 | Write data |
| bus_rd_i | input | 1 | Read strobe; the vector read has a side effect at the clock edge |
| bus_rdata_o | output | 32 | Read data, valid in the same cycle as the address |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The properties assume a well-formed bus. Read and write are never strobed in the same cycle, addresses are word aligned, and the source inputs are already synchronous to the clock. The stimulus stays within these assumptions. It drives every bus operation and every input change at the falling edge, runs one bus operation at a time, and holds each strobe for exactly one rising edge. Each vector read therefore takes effect once, and each change to the request line can be predicted to the cycle.

// File: rtl/ic_pkg.sv
package ic_pkg;

    localparam int IC_PRIO_W = 3;
    localparam int IC_BANK_W = 32;
    localparam int IC_ADDR_W = 10;

    // Per-source configuration word; edge_sel sits in bit 0
    typedef struct packed {
        logic [IC_PRIO_W-1:0] level;
        logic                 edge_sel;
    } src_cfg_t;

    localparam int IC_CFG_W = $bits(src_cfg_t);

    localparam logic [IC_ADDR_W-1:0] A_CTRL     = 10'h000;
    localparam logic [IC_ADDR_W-1:0] A_SRST     = 10'h004;
    localparam logic [IC_ADDR_W-1:0] A_VEC      = 10'h008;
    localparam logic [IC_ADDR_W-1:0] A_EOI      = 10'h00C;
    localparam logic [IC_ADDR_W-1:0] A_SET_BASE = 10'h040;
    localparam logic [IC_ADDR_W-1:0] A_CLR_BASE = 10'h060;
    localparam logic [IC_ADDR_W-1:0] A_CFG_BASE = 10'h200;

    function automatic logic [IC_ADDR_W-1:0] set_addr(input int b);
        return A_SET_BASE + IC_ADDR_W'(4 * b);
    endfunction

    function automatic logic [IC_ADDR_W-1:0] clr_addr(input int b);
        return A_CLR_BASE + IC_ADDR_W'(4 * b);
    endfunction

    function automatic logic [IC_ADDR_W-1:0] cfg_addr(input int n);
        return A_CFG_BASE + IC_ADDR_W'(8 * n);
    endfunction

endpackage

// File: rtl/ic_src_cell.sv
module ic_src_cell
    import ic_pkg::*;
(
    input  logic     clk_i,
    input  logic     rst_i,
    input  logic     clr_i,
    input  logic     src_i,
    input  logic     en_set_i,
    input  logic     en_clr_i,
    input  logic     cfg_we_i,
    input  src_cfg_t cfg_wdata_i,
    output logic     en_o,
    output src_cfg_t cfg_o,
    output logic     pend_o
);

    logic src_q;
    logic edge_q;

    always_ff @(posedge clk_i) begin
        if (rst_i || clr_i) begin
            en_o   <= 1'b0;
            cfg_o  <= '0;
            src_q  <= 1'b0;
            edge_q <= 1'b0;
        end else begin
            src_q <= src_i;
            if (en_set_i)
                en_o <= 1'b1;
            else if (en_clr_i)
                en_o <= 1'b0;
            if (cfg_we_i)
                cfg_o <= cfg_wdata_i;
            // any config write with the edge bit low drops a captured edge
            if (cfg_we_i && !cfg_wdata_i.edge_sel)
                edge_q <= 1'b0;
            else if (cfg_o.edge_sel && src_i && !src_q)
                edge_q <= 1'b1;
        end
    end

    assign pend_o = en_o & (cfg_o.edge_sel ? edge_q : src_i);

endmodule

// File: rtl/ic_prio_pick.sv
module ic_prio_pick
    import ic_pkg::*;
#(
    parameter int NSRC  = 64,
    parameter int IDX_W = 7
) (
    input  logic [NSRC-1:0]      pend_i,
    input  logic [IC_PRIO_W-1:0] level_i [NSRC],
    output logic                 valid_o,
    output logic [IDX_W-1:0]     idx_o,
    output logic [IC_PRIO_W-1:0] level_o
);

    always_comb begin
        logic                 v;
        logic [IDX_W-1:0]     ix;
        logic [IC_PRIO_W-1:0] lv;
        v  = 1'b0;
        ix = '0;
        lv = '0;
        // strict compare keeps the lowest index on equal levels
        for (int i = 0; i < NSRC; i++) begin
            if (pend_i[i] && (!v || level_i[i] > lv)) begin
                v  = 1'b1;
                ix = IDX_W'(i);
                lv = level_i[i];
            end
        end
        valid_o = v;
        idx_o   = ix;
        level_o = lv;
    end

endmodule

// File: rtl/irq_ctrl_top.sv
module irq_ctrl_top
    import ic_pkg::*;
#(
    parameter int NSRC = 64
) (
    input  logic                 clk_i,
    input  logic                 rst_i,
    input  logic [NSRC-1:0]      src_i,
    input  logic [IC_ADDR_W-1:0] bus_addr_i,
    input  logic                 bus_wr_i,
    input  logic [31:0]          bus_wdata_i,
    input  logic                 bus_rd_i,
    output logic [31:0]          bus_rdata_o,
    output logic                 irq_o
);

    localparam int NBANK = NSRC / IC_BANK_W;
    localparam int IDX_W = $clog2(NSRC) + 1;

    logic [NSRC-1:0]      en_q;
    logic [NSRC-1:0]      pend;
    src_cfg_t             cfg_q [NSRC];
    logic [IC_PRIO_W-1:0] lvl [NSRC];
    src_cfg_t             cfg_wr;

    logic                 soft_clr;
    logic                 wr_ctrl;
    logic                 wr_eoi;
    logic                 rd_vec;
    logic                 gen_q;
    logic                 busy_q;
    logic [IC_PRIO_W-1:0] svc_lvl_q;
    logic                 irq_q;

    logic                 pick_valid;
    logic [IDX_W-1:0]     pick_idx;
    logic [IC_PRIO_W-1:0] pick_level;

    assign soft_clr = bus_wr_i && (bus_addr_i == A_SRST) && bus_wdata_i[0];
    assign wr_ctrl  = bus_wr_i && (bus_addr_i == A_CTRL);
    assign wr_eoi   = bus_wr_i && (bus_addr_i == A_EOI);
    assign rd_vec   = bus_rd_i && (bus_addr_i == A_VEC);
    assign cfg_wr   = bus_wdata_i[IC_CFG_W-1:0];

    for (genvar n = 0; n < NSRC; n++) begin : g_src
        localparam int B = n / IC_BANK_W;
        localparam int K = n % IC_BANK_W;
        logic set_s;
        logic clr_s;
        logic cfg_s;

        assign set_s = bus_wr_i && (bus_addr_i == set_addr(B)) && bus_wdata_i[K];
        assign clr_s = bus_wr_i && (bus_addr_i == clr_addr(B)) && bus_wdata_i[K];
        assign cfg_s = bus_wr_i && (bus_addr_i == cfg_addr(n));

        ic_src_cell u_cell (
            .clk_i      (clk_i),
            .rst_i      (rst_i),
            .clr_i      (soft_clr),
            .src_i      (src_i[n]),
            .en_set_i   (set_s),
            .en_clr_i   (clr_s),
            .cfg_we_i   (cfg_s),
            .cfg_wdata_i(cfg_wr),
            .en_o       (en_q[n]),
            .cfg_o      (cfg_q[n]),
            .pend_o     (pend[n])
        );

        assign lvl[n] = cfg_q[n].level;
    end

    ic_prio_pick #(
        .NSRC (NSRC),
        .IDX_W(IDX_W)
    ) u_pick (
        .pend_i (pend),
        .level_i(lvl),
        .valid_o(pick_valid),
        .idx_o  (pick_idx),
        .level_o(pick_level)
    );

    always_ff @(posedge clk_i) begin
        if (rst_i || soft_clr) begin
            gen_q     <= 1'b0;
            busy_q    <= 1'b0;
            svc_lvl_q <= '0;
            irq_q     <= 1'b0;
        end else begin
            if (wr_ctrl)
                gen_q <= bus_wdata_i[0];
            if (wr_eoi)
                busy_q <= 1'b0;
            else if (rd_vec && pick_valid) begin
                busy_q    <= 1'b1;
                svc_lvl_q <= pick_level;
            end
            irq_q <= gen_q && pick_valid && (!busy_q || pick_level > svc_lvl_q);
        end
    end

    assign irq_o = irq_q;

    always_comb begin
        bus_rdata_o = '0;
        if (bus_addr_i == A_CTRL)
            bus_rdata_o[0] = gen_q;
        if (bus_addr_i == A_VEC)
            bus_rdata_o[IDX_W-1:0] = pick_valid ? pick_idx : IDX_W'(NSRC);
        for (int b = 0; b < NBANK; b++) begin
            if (bus_addr_i == set_addr(b) || bus_addr_i == clr_addr(b))
                bus_rdata_o = en_q[b*IC_BANK_W +: IC_BANK_W];
        end
        for (int n = 0; n < NSRC; n++) begin
            if (bus_addr_i == cfg_addr(n))
                bus_rdata_o[IC_CFG_W-1:0] = cfg_q[n];
        end
    end

endmodule

// File: rtl/ic_checker.sv
module ic_checker
    import ic_pkg::*;
#(
    parameter int NSRC = 64
) (
    input logic                 clk_i,
    input logic                 rst_i,
    input logic [IC_ADDR_W-1:0] bus_addr_i,
    input logic                 bus_wr_i,
    input logic [31:0]          bus_wdata_i,
    input logic                 bus_rd_i,
    input logic [31:0]          bus_rdata_o,
    input logic                 irq_o,
    input logic                 gen_q,
    input logic [NSRC-1:0]      en_q,
    input logic [NSRC-1:0]      pend
);

    localparam int IDX_W = $clog2(NSRC) + 1;

    // R8
    irq_gate_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !$past(gen_q) |-> !irq_o);

    // R10
    soft_reset_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (bus_wr_i && bus_addr_i == A_SRST && bus_wdata_i[0])
        |=> (en_q == '0 && !gen_q && !irq_o));

    // R2
    set_bank0_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (bus_wr_i && bus_addr_i == A_SET_BASE)
        |=> ((en_q[31:0] & $past(bus_wdata_i)) == $past(bus_wdata_i)));

    // R3
    clr_bank0_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (bus_wr_i && bus_addr_i == A_CLR_BASE)
        |=> ((en_q[31:0] & $past(bus_wdata_i)) == 32'h0));

    // R7
    vec_pending_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (bus_rd_i && bus_addr_i == A_VEC && bus_rdata_o < 32'(NSRC))
        |-> pend[bus_rdata_o[IDX_W-2:0]]);

    // R7
    vec_none_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (bus_rd_i && bus_addr_i == A_VEC && pend == '0)
        |-> (bus_rdata_o == 32'(NSRC)));

endmodule

bind irq_ctrl_top ic_checker #(.NSRC(NSRC)) u_ic_checker (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .bus_addr_i (bus_addr_i),
    .bus_wr_i   (bus_wr_i),
    .bus_wdata_i(bus_wdata_i),
    .bus_rd_i   (bus_rd_i),
    .bus_rdata_o(bus_rdata_o),
    .irq_o      (irq_o),
    .gen_q      (gen_q),
    .en_q       (en_q),
    .pend       (pend)
);

// File: tb/test_irq_ctrl_top.sv
module test_irq_ctrl_top;
    import ic_pkg::*;

    localparam int NSRC = 64;

    logic                 clk = 1'b0;
    logic                 rst;
    logic [NSRC-1:0]      src;
    logic [IC_ADDR_W-1:0] addr;
    logic                 wr;
    logic [31:0]          wdata;
    logic                 rd;
    logic [31:0]          rdata;
    logic                 irq;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    irq_ctrl_top #(.NSRC(NSRC)) i_irq_ctrl_top (
        .clk_i      (clk),
        .rst_i      (rst),
        .src_i      (src),
        .bus_addr_i (addr),
        .bus_wr_i   (wr),
        .bus_wdata_i(wdata),
        .bus_rd_i   (rd),
        .bus_rdata_o(rdata),
        .irq_o      (irq)
    );

    // row: {is_read, address, data-or-expected}
    localparam int NROW = 12;
    localparam logic [42:0] TBL [NROW] = '{
        {1'b1, 10'h000, 32'h0000_0000},  // R1 control clear
        {1'b1, 10'h040, 32'h0000_0000},  // R1 enables clear
        {1'b0, 10'h040, 32'h0000_00F0},
        {1'b1, 10'h040, 32'h0000_00F0},  // R2
        {1'b0, 10'h044, 32'h8000_0001},
        {1'b1, 10'h044, 32'h8000_0001},  // R2 high bank
        {1'b0, 10'h060, 32'h0000_0030},
        {1'b1, 10'h060, 32'h0000_00C0},  // R3 read at clear address
        {1'b1, 10'h040, 32'h0000_00C0},  // R3
        {1'b0, 10'h230, 32'h0000_000A},
        {1'b1, 10'h230, 32'h0000_000A},  // R4 level 5, level mode
        {1'b1, 10'h008, 32'h0000_0040}   // R1 R7 nothing pending
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [IC_ADDR_W-1:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic bus_read(input logic [IC_ADDR_W-1:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a; rd = 1'b1;
        #1 d = rdata;
        @(negedge clk);
        rd = 1'b0;
    endtask

    task automatic read_check(input string req, input logic [IC_ADDR_W-1:0] a, input logic [31:0] exp);
        logic [31:0] d;
        bus_read(a, d);
        check(req, d, exp);
    endtask

    task automatic wait2();
        repeat (2) @(negedge clk);
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

    initial begin
        rst = 1'b1; src = '0; addr = '0; wr = 1'b0; wdata = '0; rd = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 irq", {31'b0, irq}, 32'h0);

        for (int i = 0; i < NROW; i++) begin
            if (TBL[i][42])
                read_check("R1-R4 table", TBL[i][41:32], TBL[i][31:0]);
            else
                bus_write(TBL[i][41:32], TBL[i][31:0]);
        end

        // R8: request held off while generation is disabled
        src[6] = 1'b1;
        wait2();
        check("R8 gated", {31'b0, irq}, 32'h0);
        bus_write(A_CTRL, 32'h1);
        wait2();
        check("R8 raised", {31'b0, irq}, 32'h1);
        read_check("R5 R7 vector", A_VEC, 32'd6);
        wait2();
        check("R9 in service", {31'b0, irq}, 32'h0);

        // R9: a strictly higher level breaks through
        bus_write(cfg_addr(7), 32'hE);
        src[7] = 1'b1;
        wait2();
        check("R9 higher level", {31'b0, irq}, 32'h1);
        read_check("R7 higher wins", A_VEC, 32'd7);
        wait2();
        check("R9 masked again", {31'b0, irq}, 32'h0);
        bus_write(A_EOI, 32'h0);
        wait2();
        check("R9 eoi", {31'b0, irq}, 32'h1);
        src[7] = 1'b0;

        // R7: equal levels pick the lowest number
        bus_write(cfg_addr(32), 32'hA);
        src[32] = 1'b1;
        read_check("R7 tie", A_VEC, 32'd6);
        bus_write(A_EOI, 32'h0);
        bus_write(cfg_addr(32), 32'hC);
        read_check("R7 level order", A_VEC, 32'd32);
        bus_write(A_EOI, 32'h0);
        src[6] = 1'b0; src[32] = 1'b0;

        // R5: a source that is not enabled has no effect
        src[33] = 1'b1;
        wait2();
        read_check("R5 disabled", A_VEC, 32'd64);
        check("R5 irq", {31'b0, irq}, 32'h0);
        src[33] = 1'b0;

        // R6: edge capture and clear by rewriting the config word
        bus_write(cfg_addr(63), 32'h5);
        @(negedge clk) src[63] = 1'b1;
        @(negedge clk) src[63] = 1'b0;
        wait2();
        read_check("R6 latched", A_VEC, 32'd63);
        bus_write(A_EOI, 32'h0);
        wait2();
        check("R6 irq", {31'b0, irq}, 32'h1);
        bus_write(cfg_addr(63), 32'h4);
        bus_write(cfg_addr(63), 32'h5);
        read_check("R6 cleared", A_VEC, 32'd64);

        // R10: soft reset
        bus_write(A_SRST, 32'h1);
        read_check("R10 bank0", set_addr(0), 32'h0);
        read_check("R10 bank1", set_addr(1), 32'h0);
        read_check("R10 ctrl", A_CTRL, 32'h0);
        read_check("R10 cfg", cfg_addr(63), 32'h0);
        check("R10 irq", {31'b0, irq}, 32'h0);

        done = 1'b1;
        summary();
    end

endmodule